// File: doc/BRIEF.md
# Paged Write Cache Controller

This block sits behind a serial write front end. It collects the data bytes of one write burst in a 64-byte cache, arranged as 8 pages of 8 bytes. When the burst is committed, it programs the filled pages into a byte-addressed memory array one page at a time. Each page program takes a fixed, timed write cycle. The serial protocol decoder drives the start address, a flag that marks the first byte of a burst, byte strobes and a commit pulse. The array side receives a page address, a full page of data, a byte-enable mask and a one-cycle program strobe.

The first byte of a burst always goes to cache page 0, at the slot given by the low address bits. Later bytes fill forward and wrap around the whole cache, overwriting older entries. Cache page k is programmed to the k-th array page after the start page. Only the slots that were loaded are enabled, so array bytes that were not loaded keep their contents.

While programming runs, the block raises busy and ignores all new bytes and commits.

Top module: `burst_page_cache`

## Requirements
- R1: During and right after reset, busy is low and the program strobe is low.
- R2: The first byte of a burst (byteValid with firstByte high) goes to cache page 0 at slot startAddr[2:0]. It is programmed to array page startAddr[11:3] at that byte position.
- R3: Each further byte goes to the next cache slot. Cache page k is programmed to array page (startAddr[11:3] + k) mod 512, which may cross a row or a block boundary.
- R4: After the 64th cache slot, the slot pointer wraps to slot 0 of page 0. The later byte replaces the earlier one.
- R5: pgmMask bit j is set exactly when byte j of that page was loaded. Byte j of the page travels on pgmData[8j+7:8j]. Array bytes whose mask bit is clear are left unchanged.
- R6: Pages are programmed in ascending cache-page order, one strobe per page that holds at least one loaded byte. Pages with no loaded bytes get no strobe.
- R7: busy rises on the clock edge that samples a commit when data is loaded. It stays high for exactly 8 + WRITE_CLKS × (loaded pages) cycles. Successive strobes are at least WRITE_CLKS + 1 cycles apart.
- R8: A commit with no bytes loaded (an address-only write) leaves busy low and gives no strobe.
- R9: While busy, byteValid, firstByte and commit have no effect.
- R10: A new firstByte discards any bytes that were loaded but not committed.
- R11: When programming completes, all loaded marks are cleared, so a commit with no new bytes afterwards does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startAddr | input | ADDR_W | Byte address of the burst, taken with the first byte |
| firstByte | input | 1 | Marks the current byte as the first of a new burst |
| byteValid | input | 1 | A data byte is present this cycle |
| byteData | input | 8 | Data byte |
| commit | input | 1 | End of burst; starts programming |
| busy | output | 1 | Programming in progress |
| pgmStrobe | output | 1 | One-cycle request to program one page |
| pgmPage | output | ADDR_W-3 | Array page address for the strobe |
| pgmData | output | 64 | Page data, byte j on bits 8j+7:8j |
| pgmMask | output | 8 | Byte enables for the page |

## Verification
The bench sweeps every start offset within a page against burst lengths of 1, 3, 8, 9, 20, 63, 64 and 66 bytes. The start page is varied, and one burst is placed near the top of the array. A design that placed the first byte at cache offset 0, or that wrapped at the page boundary and not at the cache boundary, would write bytes to the wrong array addresses. Long bursts catch a missed overwrite, and short bursts catch a design that charges a write cycle for empty pages: the busy length would be off. Separate cases commit with nothing loaded, restart a burst without committing, and toggle every input during programming. A design that latched stale marks or accepted input while busy would then start a spurious program cycle.

// File: rtl/wcache_pkg.sv
package wcache_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SCAN,
    ST_WAIT
  } cacheState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;    // store byteData in the cache
    logic restart;    // this byte opens a new burst
    logic clearMask;  // drop all loaded marks
  } dpCtrl_t;

endpackage

// File: rtl/wcache_datapath.sv
module wcache_datapath
  import wcache_pkg::*;
#(
  parameter int ADDR_W         = 12,
  parameter int BYTES_PER_PAGE = 8,
  parameter int CACHE_PAGES    = 8,
  localparam int OFF_W   = $clog2(BYTES_PER_PAGE),
  localparam int PG_W    = $clog2(CACHE_PAGES),
  localparam int SLOTS   = BYTES_PER_PAGE * CACHE_PAGES,
  localparam int SLOT_W  = OFF_W + PG_W,
  localparam int APAGE_W = ADDR_W - OFF_W
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  dpCtrl_t                     ctl,
  input  logic [ADDR_W-1:0]           startAddr,
  input  logic [7:0]                  byteData,
  input  logic [PG_W-1:0]             pageSel,
  output logic [APAGE_W-1:0]          pgmPage,
  output logic [BYTES_PER_PAGE*8-1:0] pageData,
  output logic [BYTES_PER_PAGE-1:0]   pageMask,
  output logic                        anyValid
);

  logic [7:0]         cacheMem [SLOTS];
  logic [SLOTS-1:0]   loaded;
  logic [SLOT_W-1:0]  wrPtr;
  logic [SLOT_W-1:0]  slot;
  logic [APAGE_W-1:0] basePage;

  // a restart lands in page 0 at the address's byte offset
  assign slot = ctl.restart ? SLOT_W'(startAddr[OFF_W-1:0]) : wrPtr;

  always_ff @(posedge clk) begin
    if (ctl.capture) cacheMem[slot] <= byteData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loaded   <= '0;
      wrPtr    <= '0;
      basePage <= '0;
    end else if (ctl.clearMask) begin
      loaded <= '0;
    end else if (ctl.capture) begin
      loaded <= (ctl.restart ? '0 : loaded) | (SLOTS'(1) << slot);
      wrPtr  <= slot + SLOT_W'(1);  // wraps at the cache size
      if (ctl.restart) basePage <= startAddr[ADDR_W-1:OFF_W];
    end
  end

  for (genvar j = 0; j < BYTES_PER_PAGE; j++) begin : gPageByte
    assign pageData[8*j +: 8] = cacheMem[{pageSel, OFF_W'(j)}];
    assign pageMask[j]        = loaded[{pageSel, OFF_W'(j)}];
  end

  assign pgmPage  = basePage + APAGE_W'(pageSel);
  assign anyValid = |loaded;

endmodule

// File: rtl/wcache_ctrl.sv
module wcache_ctrl
  import wcache_pkg::*;
#(
  parameter int CACHE_PAGES = 8,
  parameter int WRITE_CLKS  = 64,
  localparam int PG_W  = $clog2(CACHE_PAGES),
  localparam int TMR_W = $clog2(WRITE_CLKS + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            byteValid,
  input  logic            firstByte,
  input  logic            commit,
  input  logic            anyValid,
  input  logic            pageHasData,
  output dpCtrl_t         ctl,
  output logic [PG_W-1:0] pageSel,
  output logic            busy,
  output logic            pgmStrobe
);

  cacheState_t      state;
  logic [TMR_W-1:0] timer;
  logic             lastPage;

  assign lastPage = (pageSel == PG_W'(CACHE_PAGES - 1));
  assign busy     = (state != ST_IDLE);

  always_comb begin
    ctl       = '0;
    pgmStrobe = 1'b0;
    case (state)
      ST_IDLE: begin
        ctl.capture = byteValid && !commit;
        ctl.restart = byteValid && firstByte && !commit;
      end
      ST_SCAN: begin
        pgmStrobe     = pageHasData;
        ctl.clearMask = !pageHasData && lastPage;
      end
      ST_WAIT: ctl.clearMask = (timer == '0) && lastPage;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      pageSel <= '0;
      timer   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (commit && anyValid) begin
          state   <= ST_SCAN;
          pageSel <= '0;
        end
        ST_SCAN: begin
          if (pageHasData) begin
            state <= ST_WAIT;
            timer <= TMR_W'(WRITE_CLKS - 1);
          end else if (lastPage) begin
            state <= ST_IDLE;
          end else begin
            pageSel <= pageSel + PG_W'(1);
          end
        end
        ST_WAIT: begin
          if (timer != '0) begin
            timer <= timer - TMR_W'(1);
          end else if (lastPage) begin
            state <= ST_IDLE;
          end else begin
            state   <= ST_SCAN;
            pageSel <= pageSel + PG_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/burst_page_cache.sv
module burst_page_cache
  import wcache_pkg::*;
#(
  parameter int ADDR_W         = 12,
  parameter int BYTES_PER_PAGE = 8,
  parameter int CACHE_PAGES    = 8,
  parameter int WRITE_CLKS     = 64,
  localparam int OFF_W = $clog2(BYTES_PER_PAGE),
  localparam int PG_W  = $clog2(CACHE_PAGES)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [ADDR_W-1:0]           startAddr,
  input  logic                        firstByte,
  input  logic                        byteValid,
  input  logic [7:0]                  byteData,
  input  logic                        commit,
  output logic                        busy,
  output logic                        pgmStrobe,
  output logic [ADDR_W-OFF_W-1:0]     pgmPage,
  output logic [BYTES_PER_PAGE*8-1:0] pgmData,
  output logic [BYTES_PER_PAGE-1:0]   pgmMask
);

  dpCtrl_t         ctl;
  logic [PG_W-1:0] pageSel;
  logic            anyValid;

  wcache_ctrl #(
    .CACHE_PAGES(CACHE_PAGES),
    .WRITE_CLKS (WRITE_CLKS)
  ) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .byteValid  (byteValid),
    .firstByte  (firstByte),
    .commit     (commit),
    .anyValid   (anyValid),
    .pageHasData(|pgmMask),
    .ctl        (ctl),
    .pageSel    (pageSel),
    .busy       (busy),
    .pgmStrobe  (pgmStrobe)
  );

  wcache_datapath #(
    .ADDR_W        (ADDR_W),
    .BYTES_PER_PAGE(BYTES_PER_PAGE),
    .CACHE_PAGES   (CACHE_PAGES)
  ) uData (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .startAddr(startAddr),
    .byteData (byteData),
    .pageSel  (pageSel),
    .pgmPage  (pgmPage),
    .pageData (pgmData),
    .pageMask (pgmMask),
    .anyValid (anyValid)
  );

endmodule

// File: rtl/wcache_checker.sv
module wcache_checker #(
  parameter int BYTES_PER_PAGE = 8,
  parameter int WRITE_CLKS     = 64,
  localparam int GAP_W = $clog2(WRITE_CLKS + 2) + 1
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      commit,
  input logic                      byteValid,
  input logic                      busy,
  input logic                      pgmStrobe,
  input logic [BYTES_PER_PAGE-1:0] pgmMask,
  input logic                      anyValid
);

  logic [GAP_W-1:0] gap;
  logic             seen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gap  <= '0;
      seen <= 1'b0;
    end else begin
      if (pgmStrobe) begin
        gap  <= GAP_W'(1);
        seen <= 1'b1;
      end else begin
        if (!busy) seen <= 1'b0;
        if (gap <= GAP_W'(WRITE_CLKS)) gap <= gap + GAP_W'(1);
      end
    end
  end

  AST_STROBE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    pgmStrobe |-> busy) else $error("strobe while idle"); // R7

  AST_NO_EMPTY_PAGE: assert property (@(posedge clk) disable iff (!rstN)
    pgmStrobe |-> (pgmMask != '0)) else $error("empty page programmed"); // R6

  AST_COMMIT_STARTS: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && commit && anyValid) |=> busy) else $error("commit ignored"); // R7

  AST_EMPTY_COMMIT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && commit && !anyValid) |=> !busy) else $error("empty commit started"); // R8

  AST_WRITE_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    (pgmStrobe && seen) |-> (gap > GAP_W'(WRITE_CLKS))) else $error("write cycle cut short"); // R7

  AST_MASK_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> !anyValid) else $error("marks left after programming"); // R11

  AST_BUSY_IGNORES_BYTES: assert property (@(posedge clk) disable iff (!rstN)
    (busy && byteValid) |=> (!busy || anyValid == $past(anyValid))) else $error("byte taken while busy"); // R9

endmodule

bind burst_page_cache wcache_checker #(
  .BYTES_PER_PAGE(BYTES_PER_PAGE),
  .WRITE_CLKS    (WRITE_CLKS)
) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .commit   (commit),
  .byteValid(byteValid),
  .busy     (busy),
  .pgmStrobe(pgmStrobe),
  .pgmMask  (pgmMask),
  .anyValid (anyValid)
);

// File: tb/burst_page_cache_test.sv
module burst_page_cache_test;
  localparam int AW     = 12;
  localparam int WC     = 5;
  localparam int SLOTS  = 64;
  localparam int APAGES = 512;
  localparam int ABYTES = 4096;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] startAddr = '0;
  logic          firstByte = 1'b0;
  logic          byteValid = 1'b0;
  logic [7:0]    byteData = '0;
  logic          commit = 1'b0;
  logic          busy, pgmStrobe;
  logic [AW-4:0] pgmPage;
  logic [63:0]   pgmData;
  logic [7:0]    pgmMask;

  burst_page_cache #(.ADDR_W(AW), .BYTES_PER_PAGE(8), .CACHE_PAGES(8), .WRITE_CLKS(WC)) uut (
    .clk(clk), .rstN(rstN), .startAddr(startAddr), .firstByte(firstByte),
    .byteValid(byteValid), .byteData(byteData), .commit(commit), .busy(busy),
    .pgmStrobe(pgmStrobe), .pgmPage(pgmPage), .pgmData(pgmData), .pgmMask(pgmMask));

  always #2 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, busyCnt = 0, stCount = 0;
  int stPage [16];
  logic [7:0] stMask [16];
  logic [7:0] arr [ABYTES];
  logic [7:0] expArr [ABYTES];

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // array model and monitors, sampled away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (busy) busyCnt++;
    if (pgmStrobe) begin
      for (int j = 0; j < 8; j++)
        if (pgmMask[j]) arr[int'(pgmPage) * 8 + j] = pgmData[8*j +: 8];
      if (stCount < 16) begin
        stPage[stCount] = int'(pgmPage);
        stMask[stCount] = pgmMask;
      end
      stCount++;
    end
    if (cyc > 150000) begin
      check(1'b0, "watchdog", "cycles", cyc, 150000);
      finishRun();
    end
  end

  function automatic logic [7:0] dataOf(input int seed, input int i);
    return 8'(seed * 29 + i * 11 + 5);
  endfunction

  task automatic loadBytes(input int addr, input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      startAddr = AW'(addr);
      firstByte = (i == 0);
      byteValid = 1'b1;
      byteData  = dataOf(seed, i);
    end
    @(negedge clk);
    byteValid = 1'b0;
    firstByte = 1'b0;
  endtask

  task automatic commitPulse();
    @(negedge clk);
    commit  = 1'b1;
    busyCnt = 0;
    stCount = 0;
    @(negedge clk);
    commit = 1'b0;
  endtask

  // empty commit: busy must stay low and nothing be programmed
  task automatic emptyCommit(input string req);
    int hi;
    hi = 0;
    commitPulse();
    for (int c = 0; c < 12; c++) begin
      if (busy) hi++;
      @(negedge clk);
    end
    check(hi == 0, req, "busy cycles after empty commit", hi, 0);
    check(stCount == 0, req, "strobes after empty commit", stCount, 0);
  endtask

  task automatic runBurst(input int addr, input int n, input int seed, input bit disturb);
    int owner [SLOTS];
    logic [7:0] pMask [8];
    int expPage [8];
    logic [7:0] expMask [8];
    int off, base, nPages, bad, firstBad, seqBad;
    string req;
    off  = addr % 8;
    base = addr / 8;
    for (int s = 0; s < SLOTS; s++) owner[s] = -1;
    for (int i = 0; i < n; i++) owner[(off + i) % SLOTS] = i;
    for (int k = 0; k < 8; k++) pMask[k] = '0;
    for (int s = 0; s < SLOTS; s++) if (owner[s] >= 0) begin
      pMask[s / 8][s % 8] = 1'b1;
      expArr[((base + s / 8) % APAGES) * 8 + s % 8] = dataOf(seed, owner[s]);
    end
    nPages = 0;
    for (int k = 0; k < 8; k++) if (pMask[k] != '0) begin
      expPage[nPages] = (base + k) % APAGES;
      expMask[nPages] = pMask[k];
      nPages++;
    end

    loadBytes(addr, n, seed);
    commitPulse();
    check(busy == 1'b1, "R7", "busy after commit", int'(busy), 1);
    if (disturb) begin
      for (int c = 0; c < 6; c++) begin
        startAddr = AW'(addr ^ 12'h5a3);
        firstByte = 1'b1;
        byteValid = 1'b1;
        byteData  = 8'hc3;
        commit    = c[0];
        @(negedge clk);
      end
      firstByte = 1'b0;
      byteValid = 1'b0;
      commit    = 1'b0;
    end
    while (busy) @(negedge clk);

    check(busyCnt == 8 + WC * nPages, "R7", "busy length", busyCnt, 8 + WC * nPages);
    check(stCount == nPages, "R6", "page strobes", stCount, nPages);
    seqBad = 0;
    for (int p = 0; p < nPages && p < stCount; p++)
      if (stPage[p] != expPage[p] || stMask[p] != expMask[p]) seqBad++;
    check(seqBad == 0, "R5", "page/mask mismatches", seqBad, 0);

    bad = 0;
    firstBad = -1;
    for (int a = 0; a < ABYTES; a++) if (arr[a] !== expArr[a]) begin
      if (firstBad < 0) firstBad = a;
      bad++;
    end
    if (disturb) req = "R9";
    else if (n == 1) req = "R2";
    else if (n > SLOTS) req = "R4";
    else req = "R3";
    check(bad == 0, req, $sformatf("array bytes wrong (first at %0d)", firstBad), bad, 0);
  endtask

  int lens [8] = '{1, 3, 8, 9, 20, 63, 64, 66};

  initial begin
    for (int a = 0; a < ABYTES; a++) begin
      arr[a]    = 8'(a * 13 + 7);
      expArr[a] = 8'(a * 13 + 7);
    end
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R1", "busy in reset", int'(busy), 0);
    check(pgmStrobe == 1'b0, "R1", "strobe in reset", int'(pgmStrobe), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);

    emptyCommit("R8");

    for (int off = 0; off < 8; off++)
      for (int li = 0; li < 8; li++)
        runBurst(((off * 71 + li * 97 + 3) % APAGES) * 8 + off, lens[li], off * 8 + li, 1'b0);

    // top of the array: cache pages map across the wrap to page 0
    runBurst(510 * 8 + 5, 64, 201, 1'b0);
    emptyCommit("R11");

    // uncommitted bytes must be discarded by a new first byte
    loadBytes(40 * 8 + 2, 30, 77);
    runBurst(300 * 8 + 6, 5, 78, 1'b0);
    check(1'b1, "R10", "restart burst compared above", 0, 0);
    runBurst(120 * 8 + 1, 12, 79, 1'b0);

    // inputs toggled during programming must be ignored
    runBurst(222 * 8 + 4, 10, 90, 1'b1);
    emptyCommit("R9");

    finishRun();
  end

endmodule